// File: doc/BRIEF.md
# Bank Row-State Tracker and Activate Spacer

This block keeps the open-row picture of one pseudo-channel of a stacked DRAM device: eight bank groups of four banks, 32 banks in all, each either precharged (empty) or holding one open row out of 32768. Every decoded request arrives as a bank group, a bank and a 15-bit row on a valid/ready port. The block sorts it into one of three classes and reports the access latency in clock cycles that the class implies. A row hit costs CL. A miss to an empty bank costs tRCD + CL. A conflict with a different open row costs tRP + tRCD + CL.

A miss or a conflict needs an activate. Consecutive activates must be spaced in time. The spacing is long (tRRD_L) when both activates fall in the same bank group and short (tRRD_S) when they fall in different groups. The block holds the handshake off until the applicable spacing has passed. Hits never wait. A granted activate records the new row in the target bank. A precharge-all input empties every bank at once. The result is registered and appears one cycle after the request is accepted.

Top module: `bank_row_tracker`

## Requirements
- R1: A synchronous active-low reset leaves every bank empty, marks the activate spacing as expired, so the first activate after reset is accepted in the cycle it is presented, and holds rspGrant low.
- R2: A request to a bank whose open row equals the requested row is a hit. It is reported as rspClass = 0 with rspLatency = CL.
- R3: A request to an empty bank is a miss. It is reported as rspClass = 1 with rspLatency = TRCD + CL, and the bank then holds the requested row.
- R4: A request to a bank holding a different row is a conflict. It is reported as rspClass = 2 with rspLatency = TRP + TRCD + CL, and the bank then holds the requested row.
- R5: An activate (miss or conflict) in the same bank group as the previous activate is accepted no earlier than TRRD_L clock edges after the previous one. reqReady stays low until then, and the request is accepted on exactly that edge when it is already waiting.
- R6: An activate in a different bank group from the previous activate is accepted no earlier than TRRD_S edges after the previous one, and exactly then when it is already waiting.
- R7: A hit is accepted in the cycle it is presented, even while the activate spacing has not yet run out.
- R8: While prechargeAll is high, reqReady is low. The clock edge then empties every bank, so the next request to any previously open row is a miss.
- R9: rspGrant is high for exactly one cycle after each accepted request (reqValid and reqReady high at a clock edge) and low otherwise. rspClass and rspLatency are valid while rspGrant is high.
- R10: Opening or replacing a row in one bank leaves the open row of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| prechargeAll | input | 1 | Empties every bank at the next edge |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqGroup | input | 3 | Target bank group |
| reqBank | input | 2 | Target bank within the group |
| reqRow | input | 15 | Requested row |
| rspGrant | output | 1 | One-cycle pulse: a request was accepted on the previous edge |
| rspClass | output | 2 | 0 hit, 1 miss, 2 conflict |
| rspLatency | output | 6 | Access latency in cycles for the reported class |

## Verification
The bench times each activate grant to the exact edge. It sends same-group activates back to back and cross-group activates back to back. A design that applied one spacing to both cases, or that compared against the wrong group, would grant early or late on one of these patterns. A hit is sent right after an activate, so a design that stalled hits behind the spacing counter shows up as a late grant. After a precharge-all, requests return to rows that were open before. Repeated hits to a neighbouring bank follow writes to another bank, which catches a table that forgets the clear or writes the wrong entry. A long stretch of mixed requests over a few rows per bank exercises all three classes against a reference model of the open rows.

// File: rtl/bank_row_pkg.sv
package bank_row_pkg;

  typedef enum logic [1:0] {
    ACC_HIT      = 2'd0,
    ACC_MISS     = 2'd1,
    ACC_CONFLICT = 2'd2
  } accClass_t;

  typedef struct packed {
    logic accept;    // request handshake completes this edge
    logic activate;  // accepted request opens a row
    logic clearAll;  // precharge every bank
  } ctlStrobe_t;

endpackage

// File: rtl/bank_row_dp.sv
module bank_row_dp
  import bank_row_pkg::*;
#(
  parameter int GROUPS          = 8,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 15,
  parameter int CL              = 14,
  parameter int TRCD            = 14,
  parameter int TRP             = 14,
  parameter int GRP_W           = $clog2(GROUPS),
  parameter int BNK_W           = $clog2(BANKS_PER_GROUP),
  parameter int LAT_W           = $clog2(TRP + TRCD + CL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GRP_W-1:0] reqGroup,
  input  logic [BNK_W-1:0] reqBank,
  input  logic [ROW_W-1:0] reqRow,
  input  ctlStrobe_t       strobe,
  output logic             needAct,
  output logic             rspGrant,
  output logic [1:0]       rspClass,
  output logic [LAT_W-1:0] rspLatency
);

  localparam int NUM_BANKS = GROUPS * BANKS_PER_GROUP;
  localparam int IDX_W     = GRP_W + BNK_W;
  localparam logic [LAT_W-1:0] LAT_HIT      = LAT_W'(CL);
  localparam logic [LAT_W-1:0] LAT_MISS     = LAT_W'(TRCD + CL);
  localparam logic [LAT_W-1:0] LAT_CONFLICT = LAT_W'(TRP + TRCD + CL);

  logic [IDX_W-1:0]     reqIdx;
  logic [NUM_BANKS-1:0] bankOpen;
  logic [ROW_W-1:0]     bankRow [NUM_BANKS];

  assign reqIdx = {reqGroup, reqBank};

  // One open-row entry per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             isOpen;
    logic [ROW_W-1:0] openRow;
    logic             writeHere;

    assign writeHere = strobe.activate && (reqIdx == IDX_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        isOpen  <= 1'b0;
        openRow <= '0;
      end else if (strobe.clearAll) begin
        isOpen  <= 1'b0;
      end else if (writeHere) begin
        isOpen  <= 1'b1;
        openRow <= reqRow;
      end
    end

    assign bankOpen[b] = isOpen;
    assign bankRow[b]  = openRow;
  end

  // Classification of the presented request
  accClass_t        classNow;
  logic [LAT_W-1:0] latencyNow;

  always_comb begin
    if (!bankOpen[reqIdx]) begin
      classNow   = ACC_MISS;
      latencyNow = LAT_MISS;
    end else if (bankRow[reqIdx] == reqRow) begin
      classNow   = ACC_HIT;
      latencyNow = LAT_HIT;
    end else begin
      classNow   = ACC_CONFLICT;
      latencyNow = LAT_CONFLICT;
    end
  end

  assign needAct = (classNow != ACC_HIT);

  // Registered result
  accClass_t        classQ;
  logic [LAT_W-1:0] latencyQ;
  logic             grantQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ   <= 1'b0;
      classQ   <= ACC_HIT;
      latencyQ <= '0;
    end else begin
      grantQ <= strobe.accept;
      if (strobe.accept) begin
        classQ   <= classNow;
        latencyQ <= latencyNow;
      end
    end
  end

  assign rspGrant   = grantQ;
  assign rspClass   = classQ;
  assign rspLatency = latencyQ;

endmodule

// File: rtl/bank_row_ctl.sv
module bank_row_ctl
  import bank_row_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int TRRD_L = 4,
  parameter int TRRD_S = 2,
  parameter int GRP_W  = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [GRP_W-1:0] reqGroup,
  input  logic             needAct,
  input  logic             prechargeAll,
  output logic             reqReady,
  output ctlStrobe_t       strobe
);

  localparam int CNT_W = $clog2(TRRD_L + 1);
  localparam logic [CNT_W-1:0] GAP_LONG  = CNT_W'(TRRD_L);
  localparam logic [CNT_W-1:0] GAP_SHORT = CNT_W'(TRRD_S);

  logic [CNT_W-1:0] sinceAct;   // edges since the last activate, saturating
  logic [GRP_W-1:0] lastGroup;
  logic [CNT_W-1:0] gapNeeded;
  logic             spacingOk;

  assign gapNeeded = (reqGroup == lastGroup) ? GAP_LONG : GAP_SHORT;
  assign spacingOk = (sinceAct >= gapNeeded);
  assign reqReady  = !prechargeAll && (!needAct || spacingOk);

  always_comb begin
    strobe.accept   = reqValid && reqReady;
    strobe.activate = reqValid && reqReady && needAct;
    strobe.clearAll = prechargeAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct  <= GAP_LONG;
      lastGroup <= '0;
    end else if (strobe.activate) begin
      sinceAct  <= CNT_W'(1);
      lastGroup <= reqGroup;
    end else if (sinceAct < GAP_LONG) begin
      sinceAct  <= sinceAct + CNT_W'(1);
    end
  end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import bank_row_pkg::*;
#(
  parameter int GROUPS          = 8,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 15,
  parameter int CL              = 14,
  parameter int TRCD            = 14,
  parameter int TRP             = 14,
  parameter int TRRD_L          = 4,
  parameter int TRRD_S          = 2,
  parameter int GRP_W           = $clog2(GROUPS),
  parameter int BNK_W           = $clog2(BANKS_PER_GROUP),
  parameter int LAT_W           = $clog2(TRP + TRCD + CL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prechargeAll,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [GRP_W-1:0] reqGroup,
  input  logic [BNK_W-1:0] reqBank,
  input  logic [ROW_W-1:0] reqRow,
  output logic             rspGrant,
  output logic [1:0]       rspClass,
  output logic [LAT_W-1:0] rspLatency
);

  ctlStrobe_t ctlStrobe;
  logic       needAct;
  logic       actPulse;

  assign actPulse = ctlStrobe.activate;

  bank_row_ctl #(
    .GROUPS (GROUPS),
    .TRRD_L (TRRD_L),
    .TRRD_S (TRRD_S),
    .GRP_W  (GRP_W)
  ) ctl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqGroup     (reqGroup),
    .needAct      (needAct),
    .prechargeAll (prechargeAll),
    .reqReady     (reqReady),
    .strobe       (ctlStrobe)
  );

  bank_row_dp #(
    .GROUPS          (GROUPS),
    .BANKS_PER_GROUP (BANKS_PER_GROUP),
    .ROW_W           (ROW_W),
    .CL              (CL),
    .TRCD            (TRCD),
    .TRP             (TRP),
    .GRP_W           (GRP_W),
    .BNK_W           (BNK_W),
    .LAT_W           (LAT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqGroup   (reqGroup),
    .reqBank    (reqBank),
    .reqRow     (reqRow),
    .strobe     (ctlStrobe),
    .needAct    (needAct),
    .rspGrant   (rspGrant),
    .rspClass   (rspClass),
    .rspLatency (rspLatency)
  );

endmodule

// File: rtl/bank_row_chk.sv
module bank_row_chk #(
  parameter int CL     = 14,
  parameter int TRCD   = 14,
  parameter int TRP    = 14,
  parameter int TRRD_L = 4,
  parameter int TRRD_S = 2,
  parameter int GRP_W  = 3,
  parameter int LAT_W  = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             prechargeAll,
  input logic             reqValid,
  input logic             reqReady,
  input logic [GRP_W-1:0] reqGroup,
  input logic             actPulse,
  input logic             rspGrant,
  input logic [1:0]       rspClass,
  input logic [LAT_W-1:0] rspLatency
);

  localparam int CNT_W = $clog2(TRRD_L + 1);

  // Independent record of activate timing for the spacing properties
  logic [CNT_W-1:0] seenSince;
  logic [GRP_W-1:0] seenGroup;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenSince <= CNT_W'(TRRD_L);
      seenGroup <= '0;
    end else if (actPulse) begin
      seenSince <= CNT_W'(1);
      seenGroup <= reqGroup;
    end else if (seenSince < CNT_W'(TRRD_L)) begin
      seenSince <= seenSince + CNT_W'(1);
    end
  end

  // R1: reset keeps the result port quiet
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !rspGrant);

  // R5: same-group activates keep the long spacing
  a_r5_long_gap: assert property (@(posedge clk) disable iff (!rstN)
    (actPulse && reqGroup == seenGroup) |-> seenSince >= CNT_W'(TRRD_L));

  // R6: cross-group activates keep the short spacing
  a_r6_short_gap: assert property (@(posedge clk) disable iff (!rstN)
    (actPulse && reqGroup != seenGroup) |-> seenSince >= CNT_W'(TRRD_S));

  // R8: precharge-all blocks acceptance
  a_r8_precharge_blocks: assert property (@(posedge clk) disable iff (!rstN)
    prechargeAll |-> !reqReady);

  // R9: one result per accepted request
  a_r9_grant_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspGrant);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspGrant);

  // R2, R3, R4: the reported latency belongs to the reported class
  a_r2_latency_class: assert property (@(posedge clk) disable iff (!rstN)
    rspGrant |-> ((rspClass == 2'd0 && rspLatency == LAT_W'(CL)) ||
                  (rspClass == 2'd1 && rspLatency == LAT_W'(TRCD + CL)) ||
                  (rspClass == 2'd2 && rspLatency == LAT_W'(TRP + TRCD + CL))));

endmodule

bind bank_row_tracker bank_row_chk #(
  .CL     (CL),
  .TRCD   (TRCD),
  .TRP    (TRP),
  .TRRD_L (TRRD_L),
  .TRRD_S (TRRD_S),
  .GRP_W  (GRP_W),
  .LAT_W  (LAT_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .prechargeAll (prechargeAll),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqGroup     (reqGroup),
  .actPulse     (actPulse),
  .rspGrant     (rspGrant),
  .rspClass     (rspClass),
  .rspLatency   (rspLatency)
);

// File: tb/bank_row_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_row_tracker_tb_top;

  localparam int CL = 14, TRCD = 14, TRP = 14, TRRD_L = 4, TRRD_S = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prechargeAll = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqGroup = '0;
  logic [1:0]  reqBank = '0;
  logic [14:0] reqRow = '0;
  logic        rspGrant;
  logic [1:0]  rspClass;
  logic [5:0]  rspLatency;

  bank_row_tracker dut_i (
    .clk (clk), .rstN (rstN), .prechargeAll (prechargeAll),
    .reqValid (reqValid), .reqReady (reqReady),
    .reqGroup (reqGroup), .reqBank (reqBank), .reqRow (reqRow),
    .rspGrant (rspGrant), .rspClass (rspClass), .rspLatency (rspLatency)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { int cls; int lat; string tag; } exp_t;
  exp_t expQ[$];

  bit refOpen[32];
  int refRow[32];
  int lastActEdge = -100;
  int lastActGroup = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // Driver: presents one request, times its grant, queues the expected result
  task automatic sendReq(int g, int b, int r, string note);
    int idx, cls, lat, firstEdge, accEdge, expEdge, gap;
    string tag, edgeTag;
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqGroup = 3'(g); reqBank = 2'(b); reqRow = 15'(r);
    #1;
    firstEdge = cyc + 1;
    idx = g * 4 + b;
    if (!refOpen[idx])        begin cls = 1; lat = TRCD + CL;       tag = "R3"; end
    else if (refRow[idx] == r) begin cls = 0; lat = CL;              tag = "R2"; end
    else                       begin cls = 2; lat = TRP + TRCD + CL; tag = "R4"; end
    while (!reqReady) begin @(negedge clk); #1; end
    accEdge = cyc + 1;
    if (cls == 0) begin
      expEdge = firstEdge; edgeTag = "R7";
    end else begin
      gap = (g == lastActGroup) ? TRRD_L : TRRD_S;
      edgeTag = (g == lastActGroup) ? "R5" : "R6";
      expEdge = (lastActEdge + gap > firstEdge) ? lastActEdge + gap : firstEdge;
    end
    check(accEdge == expEdge, edgeTag, {"grant edge ", note}, accEdge, expEdge);
    e.cls = cls; e.lat = lat; e.tag = {tag, " ", note};
    expQ.push_back(e);
    if (cls != 0) begin
      refOpen[idx] = 1'b1; refRow[idx] = r;
      lastActEdge = accEdge; lastActGroup = g;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic prechargeStep();
    @(negedge clk);
    prechargeAll = 1'b1; reqValid = 1'b1;
    reqGroup = 3'd0; reqBank = 2'd0; reqRow = 15'(refRow[0]);
    #1;
    check(reqReady == 1'b0, "R8", "ready during precharge-all", reqReady, 0);
    @(posedge clk); #1;
    prechargeAll = 1'b0; reqValid = 1'b0;
    foreach (refOpen[i]) refOpen[i] = 1'b0;
  endtask

  // Monitor: pops the scoreboard when a result appears (R9)
  always @(negedge clk) begin
    if (rstN && rspGrant) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "result without accepted request", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(rspClass) == e.cls, e.tag, "class", rspClass, e.cls);
        check(int'(rspLatency) == e.lat, e.tag, "latency", rspLatency, e.lat);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rspGrant == 1'b0, "R1", "grant during reset", rspGrant, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(rspGrant == 1'b0, "R1", "grant after reset", rspGrant, 0);
    check(reqReady == 1'b1, "R1", "activate ready right after reset", reqReady, 1);

    // Directed patterns
    sendReq(0, 0, 5, "R1 first activate, bank empty");
    sendReq(0, 0, 5, "hit right after activate");
    sendReq(0, 1, 7, "same group back to back");
    sendReq(1, 0, 9, "other group back to back");
    sendReq(0, 0, 6, "conflict across group");
    sendReq(0, 0, 6, "hit on replaced row");
    sendReq(0, 1, 7, "R10 neighbour untouched");
    sendReq(0, 1, 8, "same group conflict");
    sendReq(0, 2, 1, "same group miss after conflict");
    for (int g = 0; g < 8; g++) sendReq(g, 3, g * 100, "group sweep");
    for (int g = 0; g < 8; g++) sendReq(g, 3, g * 100, "R10 sweep rows held");

    prechargeStep();
    sendReq(0, 0, 6, "R8 miss after precharge-all");
    sendReq(1, 0, 9, "R8 miss after precharge-all");

    // Mixed traffic over a few rows per bank
    for (int k = 0; k < 400; k++) begin
      if (k % 97 == 96) prechargeStep();
      sendReq(int'($urandom_range(7)), int'($urandom_range(3)),
              int'($urandom_range(3)), "mixed traffic");
    end

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9", "results outstanding", expQ.size(), 0);
    finishRun();
  end

endmodule